// File: doc/BRIEF.md
# Write-Masked GPIO Register Bank

This block is the register file of a 32-pin general-purpose I/O controller. It sits behind a simple 32-bit memory-mapped request port. It holds the per-pin output value and direction, plus the interrupt configuration (enable, mask, trigger type, polarity) used by a separate edge/level detection block. It also returns the live pin levels, the pending-interrupt status supplied by the detector, and a fixed identification word.

Every per-pin control word is split into two half registers, each covering 16 pins. A write to a half register carries its new values in bits 15:0 and a per-bit write enable in bits 31:16. Software can therefore set or clear any single pin bit in one write, with no read-modify-write and no race against other agents. Acknowledgement of latched interrupt events uses the same enable-qualified format: the block turns it into a one-cycle acknowledge pulse per pin, which goes to the detector.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control half register reads zero, except the two interrupt-mask halves (0x18, 0x1C), which read 0x0000FFFF. pin_o, pin_oe_o, irq_en_o, irq_type_o and irq_pol_o are zero and irq_mask_o is all ones.
- R2: On a write to a control half register, stored bit i takes wdata[i] only when wdata[16+i] is 1. Every bit whose enable is 0 keeps its value.
- R3: The low register of each pair (offsets 0x00, 0x08, 0x10, 0x18, 0x20, 0x28) controls pins 0 to 15. The high register at the next word (+4) controls pins 16 to 31, with its bit i acting on pin 16+i.
- R4: A read of a control half register returns its 16 stored bits in rdata[15:0] and zeros in rdata[31:16].
- R5: pin_o equals the data-out pair (0x00/0x04), and pin_oe_o equals the direction pair (0x08/0x0C), where 1 means output.
- R6: A read of offset 0x70 returns pin_i, with bit n holding pin n.
- R7: A read of offset 0x78 returns 0x0101157C.
- R8: A read of offset 0x50 returns irq_status_i.
- R9: A write to 0x60 (pins 0 to 15) or 0x64 (pins 16 to 31) produces, in the cycle after the write, a one-cycle eoi_o pulse on each pin whose data bit and enable bit are both 1. eoi_o is zero at all other times, and reads of 0x60 and 0x64 return zero.
- R10: Writes to unmapped offsets, to read-only offsets (0x50, 0x70, 0x78), and to any address whose bits 1:0 are not zero change no state. Reads of unmapped or misaligned addresses return zero.
- R11: irq_en_o, irq_mask_o, irq_type_o and irq_pol_o equal the enable (0x10/0x14), mask (0x18/0x1C), type (0x20/0x24) and polarity (0x28/0x2C) pairs respectively.
- R12: rdata_o is updated at the clock edge that accepts a read (req_i=1, we_i=0) and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data (data in 15:0, enables in 31:16 for paired registers) |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Live pin levels |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |
| irq_status_i | input | 32 | Pending-interrupt status from the detector |
| irq_en_o | output | 32 | Interrupt enable per pin |
| irq_mask_o | output | 32 | Interrupt mask per pin (1 blocks) |
| irq_type_o | output | 32 | Interrupt type per pin |
| irq_pol_o | output | 32 | Interrupt polarity per pin |
| eoi_o | output | 32 | One-cycle acknowledge pulse per pin |

## Verification
The write-masked update is driven with an all-enable write, a single-enable clear, an enable field that covers only part of the data field, and a zero-enable write with all data ones. These patterns separate a correct merge from one that ignores the enables, inverts them, or applies the data unqualified. Writes to the high halves use patterns with only bit 15 and bit 0 set, which exposes a swapped or shifted half. The acknowledge path is tested with data bits that have no matching enable, to show the pulse is the AND of the two fields and lasts one cycle. Misaligned and read-only addresses are written with all ones, to show that decoding uses the full address.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PIN_W     = 32;
  localparam int HALF_W    = PIN_W / 2;
  localparam int ADDR_W    = 8;
  localparam int NUM_PAIRS = 6;
  localparam int IDX_W     = 3;

  localparam int IDX_DOUT  = 0;
  localparam int IDX_DIR   = 1;
  localparam int IDX_IEN   = 2;
  localparam int IDX_IMASK = 3;
  localparam int IDX_ITYPE = 4;
  localparam int IDX_IPOL  = 5;

  localparam logic [ADDR_W-1:0] OFF_DOUT_LO  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DOUT_HI  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_DIR_LO   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_DIR_HI   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_IEN_LO   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_IEN_HI   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_IMASK_LO = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IMASK_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_ITYPE_LO = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_ITYPE_HI = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_IPOL_LO  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_IPOL_HI  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_PAIR_END = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_EOI_LO   = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_EOI_HI   = 8'h64;
  localparam logic [ADDR_W-1:0] OFF_PORT     = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_VER      = 8'h78;

  localparam logic [PIN_W-1:0] VERSION_WORD = 32'h0101_157C;

  typedef logic [NUM_PAIRS-1:0][PIN_W-1:0] ctrl_bank_t;
endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg #(
  parameter int              WIDTH   = 16,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] bit_en_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= RST_VAL;
    end else if (we_i) begin
      q <= (q & ~bit_en_i) | (data_i & bit_en_i);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_reg_pair.sv
module gpio_reg_pair import gpio_bank_pkg::*; #(
  parameter logic [PIN_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] q_o
);
  logic [1:0] wr_half;
  assign wr_half = {wr_hi_i, wr_lo_i};

  for (genvar h = 0; h < 2; h++) begin : g_half
    gpio_half_reg #(
      .WIDTH  (HALF_W),
      .RST_VAL(RST_VAL[h*HALF_W +: HALF_W])
    ) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_half[h]),
      .data_i  (wdata_i[HALF_W-1:0]),
      .bit_en_i(wdata_i[PIN_W-1:HALF_W]),
      .q_o     (q_o[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux import gpio_bank_pkg::*; (
  input  logic [ADDR_W-1:0] addr_i,
  input  ctrl_bank_t        regs_i,
  input  logic [PIN_W-1:0]  status_i,
  input  logic [PIN_W-1:0]  pins_i,
  output logic [PIN_W-1:0]  rdata_o
);
  logic             aligned;
  logic             in_pairs;
  logic [IDX_W-1:0] idx;
  logic [PIN_W-1:0] word;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_pairs = (addr_i < OFF_PAIR_END);
  assign idx      = addr_i[IDX_W+2:3];

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (idx == IDX_W'(k)) word = regs_i[k];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (in_pairs) begin
        rdata_o[HALF_W-1:0] = addr_i[2] ? word[PIN_W-1:HALF_W] : word[HALF_W-1:0];
      end else begin
        case (addr_i)
          OFF_STATUS: rdata_o = status_i;
          OFF_PORT:   rdata_o = pins_i;
          OFF_VER:    rdata_o = VERSION_WORD;
          default:    rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_bank_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_W-1:0]  wdata_i,
  output logic [PIN_W-1:0]  rdata_o,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe_o,
  input  logic [PIN_W-1:0]  irq_status_i,
  output logic [PIN_W-1:0]  irq_en_o,
  output logic [PIN_W-1:0]  irq_mask_o,
  output logic [PIN_W-1:0]  irq_type_o,
  output logic [PIN_W-1:0]  irq_pol_o,
  output logic [PIN_W-1:0]  eoi_o
);
  logic             wr, rd, aligned, pair_hit;
  logic [IDX_W-1:0] pair_idx;
  logic [HALF_W-1:0] ack_bits;
  ctrl_bank_t       regs;
  logic [PIN_W-1:0] rd_val, rdata_q, eoi_q;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign pair_hit = wr & aligned & (addr_i < OFF_PAIR_END);
  assign pair_idx = addr_i[IDX_W+2:3];

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    localparam logic [PIN_W-1:0] RV = (k == IDX_IMASK) ? {PIN_W{1'b1}} : '0;
    logic sel;
    assign sel = pair_hit & (pair_idx == IDX_W'(k));

    gpio_reg_pair #(.RST_VAL(RV)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(sel & ~addr_i[2]),
      .wr_hi_i(sel &  addr_i[2]),
      .wdata_i(wdata_i),
      .q_o    (regs[k])
    );
  end

  // acknowledge: only bits carrying both data and enable
  assign ack_bits = wdata_i[HALF_W-1:0] & wdata_i[PIN_W-1:HALF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_q <= '0;
    end else begin
      eoi_q <= '0;
      if (wr && addr_i == OFF_EOI_LO) eoi_q[HALF_W-1:0]     <= ack_bits;
      if (wr && addr_i == OFF_EOI_HI) eoi_q[PIN_W-1:HALF_W] <= ack_bits;
    end
  end

  gpio_read_mux u_rmux (
    .addr_i  (addr_i),
    .regs_i  (regs),
    .status_i(irq_status_i),
    .pins_i  (pin_i),
    .rdata_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o    = rdata_q;
  assign eoi_o      = eoi_q;
  assign pin_o      = regs[IDX_DOUT];
  assign pin_oe_o   = regs[IDX_DIR];
  assign irq_en_o   = regs[IDX_IEN];
  assign irq_mask_o = regs[IDX_IMASK];
  assign irq_type_o = regs[IDX_ITYPE];
  assign irq_pol_o  = regs[IDX_IPOL];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk import gpio_bank_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PIN_W-1:0]  wdata_i,
  input logic [PIN_W-1:0]  rdata_o,
  input logic [PIN_W-1:0]  pin_i,
  input logic [PIN_W-1:0]  pin_o,
  input logic [PIN_W-1:0]  pin_oe_o,
  input logic [PIN_W-1:0]  irq_status_i,
  input logic [PIN_W-1:0]  irq_en_o,
  input logic [PIN_W-1:0]  irq_mask_o,
  input logic [PIN_W-1:0]  irq_type_o,
  input logic [PIN_W-1:0]  irq_pol_o,
  input logic [PIN_W-1:0]  eoi_o
);
  logic is_rd, is_wr;
  assign is_rd = req_i & ~we_i;
  assign is_wr = req_i & we_i;

  assert_dout_lo_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_wr && addr_i == OFF_DOUT_LO) |=> $stable(pin_o[HALF_W-1:0]));

  assert_dout_hi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_wr && addr_i == OFF_DOUT_HI) |=> $stable(pin_o[PIN_W-1:HALF_W]));

  assert_dir_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_wr && (addr_i == OFF_DIR_LO || addr_i == OFF_DIR_HI)) |=> $stable(pin_oe_o));

  assert_mask_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_wr && (addr_i == OFF_IMASK_LO || addr_i == OFF_IMASK_HI)) |=> $stable(irq_mask_o));

  assert_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && addr_i < OFF_PAIR_END) |=> (rdata_o[PIN_W-1:HALF_W] == '0));

  assert_version_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && addr_i == OFF_VER) |=> (rdata_o == VERSION_WORD));

  assert_eoi_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o != '0) |-> $past(is_wr && (addr_i == OFF_EOI_LO || addr_i == OFF_EOI_HI)));

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rd |=> $stable(rdata_o));
endmodule

bind gpio_bank gpio_bank_chk u_chk (.*);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  import gpio_bank_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [PIN_W-1:0]  wdata = '0, pin_in = '0, status = '0;
  logic [PIN_W-1:0]  rdata, pin_out, pin_oe, ien, imask, itype, ipol, eoi;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_status_i(status), .irq_en_o(ien),
    .irq_mask_o(imask), .irq_type_o(itype), .irq_pol_o(ipol), .eoi_o(eoi)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    for (int k = 0; k < 12; k++) begin
      bus_read(8'(k * 4), d);
      check("R1", d, (k == 6 || k == 7) ? 32'h0000_FFFF : 32'h0);
    end
    check("R1", pin_out, '0);
    check("R1", pin_oe, '0);
    check("R1", imask, 32'hFFFF_FFFF);
    check("R1", ien | itype | ipol, '0);
  endtask

  task automatic test_masked_write();
    logic [31:0] d;
    bus_write(OFF_DOUT_LO, 32'hFFFF_A5A5);
    check("R2", pin_out, 32'h0000_A5A5);
    bus_write(OFF_DOUT_LO, 32'h0001_0000);
    check("R2", pin_out, 32'h0000_A5A4);
    bus_write(OFF_DOUT_LO, 32'h00F0_FFFF);
    check("R2", pin_out, 32'h0000_A5F4);
    bus_write(OFF_DOUT_LO, 32'h0000_FFFF);
    check("R2", pin_out, 32'h0000_A5F4);
    bus_read(OFF_DOUT_LO, d);
    check("R4", d, 32'h0000_A5F4);
  endtask

  task automatic test_halves();
    logic [31:0] d;
    bus_write(OFF_DOUT_HI, 32'h8001_8001);
    check("R3", pin_out, 32'h8001_A5F4);
    bus_read(OFF_DOUT_HI, d);
    check("R4", d, 32'h0000_8001);
  endtask

  task automatic test_direction();
    bus_write(OFF_DIR_LO, 32'hFFFF_00FF);
    bus_write(OFF_DIR_HI, 32'hFFFF_FF00);
    check("R5", pin_oe, 32'hFF00_00FF);
    check("R5", pin_out, 32'h8001_A5F4);
  endtask

  task automatic test_irq_cfg();
    bus_write(OFF_IEN_LO, 32'h0003_0003);
    bus_write(OFF_ITYPE_HI, 32'h0004_0004);
    bus_write(OFF_IPOL_LO, 32'hFFFF_1234);
    bus_write(OFF_IMASK_LO, 32'h0001_0000);
    check("R11", ien, 32'h0000_0003);
    check("R11", itype, 32'h0004_0000);
    check("R11", ipol, 32'h0000_1234);
    check("R11", imask, 32'hFFFF_FFFE);
  endtask

  task automatic test_reads();
    logic [31:0] d;
    pin_in = 32'hDEAD_BEEF;
    bus_read(OFF_PORT, d);
    check("R6", d, 32'hDEAD_BEEF);
    pin_in = 32'h1234_5678;
    bus_read(OFF_PORT, d);
    check("R6", d, 32'h1234_5678);
    bus_read(OFF_VER, d);
    check("R7", d, 32'h0101_157C);
    status = 32'h0F0F_0001;
    bus_read(OFF_STATUS, d);
    check("R8", d, 32'h0F0F_0001);
  endtask

  task automatic test_eoi();
    logic [31:0] d;
    check("R9", eoi, '0);
    bus_write(OFF_EOI_LO, 32'h0005_0007);
    check("R9", eoi, 32'h0000_0005);
    @(negedge clk);
    check("R9", eoi, '0);
    bus_write(OFF_EOI_HI, 32'h8000_8001);
    check("R9", eoi, 32'h8000_0000);
    @(negedge clk);
    check("R9", eoi, '0);
    bus_read(OFF_EOI_LO, d);
    check("R9", d, '0);
  endtask

  task automatic test_unmapped();
    logic [31:0] d;
    bus_write(8'h3C, 32'hFFFF_FFFF);
    bus_write(8'h01, 32'hFFFF_FFFF);
    bus_write(8'h0A, 32'hFFFF_FFFF);
    bus_write(OFF_VER, 32'h0);
    bus_write(OFF_PORT, 32'hFFFF_FFFF);
    check("R10", pin_out, 32'h8001_A5F4);
    check("R10", pin_oe, 32'hFF00_00FF);
    check("R10", imask, 32'hFFFF_FFFE);
    bus_read(8'h3C, d);
    check("R10", d, '0);
    bus_read(8'h01, d);
    check("R10", d, '0);
    bus_read(OFF_VER, d);
    check("R10", d, 32'h0101_157C);
  endtask

  task automatic test_read_timing();
    logic [31:0] d;
    bus_read(OFF_VER, d);
    repeat (3) @(negedge clk);
    check("R12", rdata, 32'h0101_157C);
    bus_write(OFF_DOUT_LO, 32'hFFFF_0000);
    check("R12", rdata, 32'h0101_157C);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = OFF_DOUT_HI;
    #1;
    check("R12", rdata, 32'h0101_157C);
    @(negedge clk);
    req = 1'b0;
    check("R12", rdata, 32'h0000_8001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_masked_write();
    test_halves();
    test_direction();
    test_irq_cfg();
    test_reads();
    test_eoi();
    test_unmapped();
    test_read_timing();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule